// File: doc/BRIEF.md
# Synchronous Buck Gate-Drive Sequencer

This block holds the per-cycle switching logic of a synchronous step-down converter. An oscillator supplies a one-clock cycle-start pulse and the PWM comparator path supplies a one-clock turn-off request. From these the block drives two gate enables: one for the high-side switch and one for the synchronous rectifier on the low side. Four comparator flags arrive asynchronously: valley overcurrent (sampled across the low-side switch), low-side gate sensed off, supply undervoltage and over-temperature. Each flag passes through a two-flop synchronizer before any decision uses it.

A switching cycle works as follows. When a cycle-start pulse arrives and the valley flag is clear, the block turns the low side off. It then waits until the low-side gate reads as fully off, and only then turns the high side on. The high side stays on until a turn-off request arrives. Both enables then stay low for a fixed number of clocks, and after that the low side conducts again. If the valley flag is set at cycle start, the low side keeps conducting and that cycle has no high-side pulse. If the gate-off feedback does not arrive in time, the cycle is abandoned and a sticky error flag is raised. Either fault flag forces both enables low. When the faults clear, the block restarts with a low-side precharge phase that charges the bootstrap capacitor before any high-side pulse is allowed.

Top module: `buck_gate_sequencer`

## Requirements
- R1: The high-side enable and the low-side enable are never high in the same clock cycle.
- R2: When a cycle-start pulse arrives while the low side conducts and the synchronized valley flag is high, the low side keeps conducting and no high-side pulse occurs in that cycle.
- R3: The high-side enable rises only in the cycle after the synchronized low-side-off feedback was seen high with both enables low.
- R4: After the high-side enable falls, both enables stay low for exactly TURN_OFF_DLY clock cycles, and then the low-side enable rises.
- R5: While the synchronized undervoltage flag is high, both enables are low and cycle-start pulses start nothing.
- R6: While the synchronized over-temperature flag is high, both enables are low.
- R7: After reset, and after every fault clears, the low-side enable comes on first (precharge). The high-side enable stays low until a cycle-start pulse is followed by a normal turn-on.
- R8: If the feedback stays low for FB_TIMEOUT cycles after the low side is switched off, the block returns to low-side conduction with no high-side pulse. It also sets the error output, which stays high until reset.
- R9: Once on, the high-side enable stays high until a turn-off request arrives, which ends the pulse.
- R10: A change on any asynchronous flag reaches the enables on the third rising clock edge after the change, and not earlier.
- R11: During reset both enables and the error output are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cycle_start_i | input | 1 | One-clock pulse at the start of each oscillator period |
| pwm_off_i | input | 1 | One-clock request to end the high-side pulse |
| valley_oc_a_i | input | 1 | Asynchronous valley overcurrent flag |
| ls_gate_off_a_i | input | 1 | Asynchronous flag: the low-side gate has discharged |
| uv_fault_a_i | input | 1 | Asynchronous supply undervoltage flag |
| ot_fault_a_i | input | 1 | Asynchronous over-temperature flag |
| hs_en_o | output | 1 | High-side gate enable |
| ls_en_o | output | 1 | Low-side gate enable |
| fb_timeout_err_o | output | 1 | Sticky error: the gate-off feedback timed out |

## Verification
The bench builds the block with TURN_OFF_DLY at its default of 4 and FB_TIMEOUT lowered to 6. At that value the abandon-and-flag path finishes within a few clocks, and the bench counts the both-low window of that path exactly. The bench models the gate feedback as the inverted low-side enable. Because of this, the three-edge synchronizer latency appears directly as the length of the dead time before the high side turns on, and the fixed delay after turn-off is counted against its parameter.

// File: rtl/buck_seq_pkg.sv
package buck_seq_pkg;

  typedef enum logic [2:0] {
    SQ_OFF    = 3'd0,
    SQ_PRECHG = 3'd1,
    SQ_LS_ON  = 3'd2,
    SQ_DT_HS  = 3'd3,
    SQ_HS_ON  = 3'd4,
    SQ_DLY_LS = 3'd5
  } sq_state_t;

  // positions in the synchronizer bank
  localparam int SB_VALLEY = 0;
  localparam int SB_LSOFF  = 1;
  localparam int SB_UV     = 2;
  localparam int SB_OT     = 3;
  localparam int SB_W      = 4;

endpackage

// File: rtl/buck_sync_bank.sv
module buck_sync_bank #(
  parameter int             W       = 4,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);

  for (genvar b = 0; b < W; b++) begin : g_bit
    logic meta_q;
    logic stab_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= RST_VAL[b];
        stab_q <= RST_VAL[b];
      end else begin
        meta_q <= async_i[b];
        stab_q <= meta_q;
      end
    end

    assign sync_o[b] = stab_q;
  end

endmodule

// File: rtl/buck_dead_timer.sv
module buck_dead_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             en_i,
  output logic [CNT_W-1:0] cnt_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i) begin
      cnt_d = '0;
    end else if (en_i) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clr_i || en_i) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/buck_seq_fsm.sv
module buck_seq_fsm
  import buck_seq_pkg::*;
#(
  parameter int TURN_OFF_DLY = 4,
  parameter int FB_TIMEOUT   = 16,
  parameter int CNT_W        = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cycle_start_i,
  input  logic             pwm_off_i,
  input  logic             valley_s_i,
  input  logic             ls_off_s_i,
  input  logic             fault_s_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             cnt_clr_o,
  output logic             cnt_en_o,
  output logic             hs_en_o,
  output logic             ls_en_o,
  output logic             err_o
);

  localparam logic [CNT_W-1:0] DLY_LAST = CNT_W'(TURN_OFF_DLY - 1);
  localparam logic [CNT_W-1:0] TMO_LAST = CNT_W'(FB_TIMEOUT - 1);

  sq_state_t state_q;
  sq_state_t state_d;
  logic      err_q;
  logic      err_set;

  always_comb begin
    state_d = state_q;
    err_set = 1'b0;
    if (fault_s_i) begin
      state_d = SQ_OFF;
    end else begin
      unique case (state_q)
        SQ_OFF:    state_d = SQ_PRECHG;
        SQ_PRECHG,
        SQ_LS_ON: begin
          if (cycle_start_i && !valley_s_i) begin
            state_d = SQ_DT_HS;
          end
        end
        SQ_DT_HS: begin
          if (ls_off_s_i) begin
            state_d = SQ_HS_ON;
          end else if (cnt_i == TMO_LAST) begin
            state_d = SQ_LS_ON;
            err_set = 1'b1;
          end
        end
        SQ_HS_ON: begin
          if (pwm_off_i) begin
            state_d = SQ_DLY_LS;
          end
        end
        SQ_DLY_LS: begin
          if (cnt_i == DLY_LAST) begin
            state_d = SQ_LS_ON;
          end
        end
        default:   state_d = SQ_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_OFF;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= 1'b0;
    end else if (err_set) begin
      err_q <= 1'b1;
    end
  end

  assign cnt_clr_o = (state_d != state_q);
  assign cnt_en_o  = !cnt_clr_o && ((state_q == SQ_DT_HS) || (state_q == SQ_DLY_LS));
  assign hs_en_o   = (state_q == SQ_HS_ON);
  assign ls_en_o   = (state_q == SQ_PRECHG) || (state_q == SQ_LS_ON);
  assign err_o     = err_q;

endmodule

// File: rtl/buck_gate_sequencer.sv
module buck_gate_sequencer
  import buck_seq_pkg::*;
#(
  parameter int TURN_OFF_DLY = 4,
  parameter int FB_TIMEOUT   = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cycle_start_i,
  input  logic pwm_off_i,
  input  logic valley_oc_a_i,
  input  logic ls_gate_off_a_i,
  input  logic uv_fault_a_i,
  input  logic ot_fault_a_i,
  output logic hs_en_o,
  output logic ls_en_o,
  output logic fb_timeout_err_o
);

  localparam int CNT_MAX = (TURN_OFF_DLY > FB_TIMEOUT) ? TURN_OFF_DLY : FB_TIMEOUT;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  // faults and overcurrent come out of reset asserted, feedback deasserted
  localparam logic [SB_W-1:0] SB_RST = (SB_W)'((1 << SB_VALLEY) | (1 << SB_UV) | (1 << SB_OT));

  logic [SB_W-1:0]  raw_flags;
  logic [SB_W-1:0]  syn_flags;
  logic             ocp_s;
  logic             ls_off_s;
  logic             fault_s;
  logic             cnt_clr;
  logic             cnt_en;
  logic [CNT_W-1:0] cnt;

  always_comb begin
    raw_flags            = '0;
    raw_flags[SB_VALLEY] = valley_oc_a_i;
    raw_flags[SB_LSOFF]  = ls_gate_off_a_i;
    raw_flags[SB_UV]     = uv_fault_a_i;
    raw_flags[SB_OT]     = ot_fault_a_i;
  end

  buck_sync_bank #(
    .W       (SB_W),
    .RST_VAL (SB_RST)
  ) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (raw_flags),
    .sync_o  (syn_flags)
  );

  assign ocp_s    = syn_flags[SB_VALLEY];
  assign ls_off_s = syn_flags[SB_LSOFF];
  assign fault_s  = syn_flags[SB_UV] | syn_flags[SB_OT];

  buck_dead_timer #(
    .CNT_W (CNT_W)
  ) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_i (cnt_clr),
    .en_i  (cnt_en),
    .cnt_o (cnt)
  );

  buck_seq_fsm #(
    .TURN_OFF_DLY (TURN_OFF_DLY),
    .FB_TIMEOUT   (FB_TIMEOUT),
    .CNT_W        (CNT_W)
  ) u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .cycle_start_i (cycle_start_i),
    .pwm_off_i     (pwm_off_i),
    .valley_s_i    (ocp_s),
    .ls_off_s_i    (ls_off_s),
    .fault_s_i     (fault_s),
    .cnt_i         (cnt),
    .cnt_clr_o     (cnt_clr),
    .cnt_en_o      (cnt_en),
    .hs_en_o       (hs_en_o),
    .ls_en_o       (ls_en_o),
    .err_o         (fb_timeout_err_o)
  );

endmodule

// File: rtl/buck_gate_sequencer_chk.sv
module buck_gate_sequencer_chk (
  input logic clk,
  input logic rst_n,
  input logic hs,
  input logic ls,
  input logic err,
  input logic cycle_start,
  input logic pwm_off,
  input logic ls_off_s,
  input logic ocp_s,
  input logic fault_s
);

  assert_no_overlap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs && ls));

  assert_valley_skip_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cycle_start && ocp_s && ls && !fault_s) |=> (ls && !hs));

  assert_hs_after_fb_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs) |-> $past(ls_off_s));

  assert_turnoff_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hs) |-> !ls);

  assert_fault_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fault_s |=> (!hs && !ls));

  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);

  assert_hs_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (hs && !pwm_off && !fault_s) |=> hs);

  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_quiet_R11: assert (!hs && !ls && !err);
    end
  end

endmodule

bind buck_gate_sequencer buck_gate_sequencer_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .hs          (hs_en_o),
  .ls          (ls_en_o),
  .err         (fb_timeout_err_o),
  .cycle_start (cycle_start_i),
  .pwm_off     (pwm_off_i),
  .ls_off_s    (ls_off_s),
  .ocp_s       (ocp_s),
  .fault_s     (fault_s)
);

// File: tb/buck_gate_sequencer_test.sv
module buck_gate_sequencer_test;

  localparam int DLY = 4;
  localparam int TMO = 6;

  logic clk = 1'b0;
  logic rst_n;
  logic cycle_start;
  logic pwm_off;
  logic valley;
  logic uv;
  logic ot;
  logic fb_auto;
  logic fb_force;
  logic ls_off_a;
  logic hs, ls, err;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  // gate feedback model: the low-side gate reads off whenever its enable is low
  assign ls_off_a = fb_auto ? !ls : fb_force;

  buck_gate_sequencer #(
    .TURN_OFF_DLY (DLY),
    .FB_TIMEOUT   (TMO)
  ) uut (
    .clk              (clk),
    .rst_n            (rst_n),
    .cycle_start_i    (cycle_start),
    .pwm_off_i        (pwm_off),
    .valley_oc_a_i    (valley),
    .ls_gate_off_a_i  (ls_off_a),
    .uv_fault_a_i     (uv),
    .ot_fault_a_i     (ot),
    .hs_en_o          (hs),
    .ls_en_o          (ls),
    .fb_timeout_err_o (err)
  );

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic pulse_start();
    cycle_start = 1'b1; tick(); cycle_start = 1'b0;
  endtask

  task automatic pulse_off();
    pwm_off = 1'b1; tick(); pwm_off = 1'b0;
  endtask

  // R11 then R7: reset quiet, then precharge on the low side
  task automatic t_reset();
    rst_n = 1'b0;
    tick(3);
    check(!hs && !ls && !err, "R11", {hs, ls, err}, 0);
    rst_n = 1'b1;
    tick(6);
    check(ls && !hs, "R7 precharge", {hs, ls}, 1);
    for (int i = 0; i < 20; i++) begin
      tick();
      if (hs) break;
    end
    check(!hs, "R7 no hs without cycle start", hs, 0);
  endtask

  // R3, R9, R4, R1: one full switching cycle
  task automatic t_cycle(int hold);
    int n;
    bit overlap;
    pulse_start();
    n = 0; overlap = 0;
    while (!hs && n < 20) begin
      if (ls) overlap = 1;
      n++; tick();
    end
    check(hs && !ls, "R3 hs on after feedback", {hs, ls}, 2);
    check(n == 3, "R10 dead time via synchronizer", n, 3);
    check(!overlap, "R1 ls low before hs", overlap, 0);
    for (int i = 0; i < hold; i++) begin
      if (!hs || ls) overlap = 1;
      tick();
    end
    check(!overlap && hs, "R9 hs held until turn-off", hs, 1);
    pulse_off();
    n = 0;
    while (!ls && n < 20) begin
      if (hs) overlap = 1;
      n++; tick();
    end
    check(n == DLY, "R4 turn-off gap", n, DLY);
    check(!overlap && ls && !hs, "R1 complement after gap", {hs, ls}, 1);
    tick(4);
  endtask

  // R2: valley flag set at cycle start skips the high-side pulse
  task automatic t_valley();
    bit seen;
    valley = 1'b1;
    tick(4);
    pulse_start();
    seen = 0;
    for (int i = 0; i < 10; i++) begin
      if (hs || !ls) seen = 1;
      tick();
    end
    check(!seen, "R2 skip on valley flag", seen, 0);
    valley = 1'b0;
    tick(4);
    t_cycle(3);
  endtask

  // R8: feedback timeout abandons the cycle and latches the error
  task automatic t_timeout();
    int n;
    bit seen;
    fb_force = 1'b0;
    fb_auto  = 1'b0;
    tick(4);
    pulse_start();
    n = 0; seen = 0;
    while (!ls && n < 30) begin
      if (hs) seen = 1;
      n++; tick();
    end
    check(n == TMO, "R8 timeout length", n, TMO);
    check(!seen, "R8 no hs on timeout", seen, 0);
    check(err, "R8 error set", err, 1);
    fb_auto = 1'b1;
    tick(4);
    t_cycle(2);
    check(err, "R8 error sticky", err, 1);
  endtask

  // R5 and R10: undervoltage while the high side is on
  task automatic t_uv();
    bit seen;
    pulse_start();
    tick(4);
    check(hs, "R9 hs on before fault", hs, 1);
    uv = 1'b1;
    tick(2);
    check(hs, "R10 no early reaction", hs, 1);
    tick();
    check(!hs && !ls, "R5 forced off", {hs, ls}, 0);
    seen = 0;
    pulse_start();
    pulse_off();
    for (int i = 0; i < 10; i++) begin
      if (hs || ls) seen = 1;
      tick();
    end
    check(!seen, "R5 no switching during fault", seen, 0);
    uv = 1'b0;
    tick(2);
    check(!ls, "R10 release latency", ls, 0);
    tick();
    check(ls && !hs, "R7 precharge after fault", {hs, ls}, 1);
    tick(4);
  endtask

  // R6: over-temperature while the low side conducts
  task automatic t_ot();
    ot = 1'b1;
    tick(4);
    check(!hs && !ls, "R6 forced off", {hs, ls}, 0);
    pulse_start();
    tick(5);
    check(!hs && !ls, "R6 held off", {hs, ls}, 0);
    ot = 1'b0;
    tick(4);
    check(ls && !hs, "R7 restart after thermal", {hs, ls}, 1);
    tick(2);
    t_cycle(5);
  endtask

  initial begin
    rst_n = 1'b0; cycle_start = 1'b0; pwm_off = 1'b0;
    valley = 1'b0; uv = 1'b0; ot = 1'b0;
    fb_auto = 1'b1; fb_force = 1'b0;
    t_reset();
    t_cycle(6);
    t_cycle(1);
    t_valley();
    t_timeout();
    t_uv();
    t_ot();
    t_reset();
    finish_run();
  end

  initial begin
    #2_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

endmodule